// File: doc/BRIEF.md
# APB System Control and Identification Registers

This block is a small APB slave that sits on a chip's peripheral bus and gathers the board-level control and identification state software needs at boot. It holds two general-purpose read/write words whose reset contents come from parameters. It reports the lock state of eight clock-generator DLLs, with a per-DLL mask and a live summary bit. It drives eight LEDs and returns the state of eight user switches. Two read-only words identify the build and list which registers are present.

There is no data stream here: every pin is either a plain APB control signal or a level-style status/control pin. The APB handshake never stalls. The ready output is held high, so every transfer completes in its access phase, and the error output is held low. Switch inputs are asynchronous and pass through a two-flop synchroniser. DLL lock inputs are evaluated live, so the summary bit always reflects the lock inputs and the mask as they are now.

Top module: `sysctl_apb_regs`

## Requirements
- R1: After reset the user words equal the parameters USER0_RST and USER1_RST, the DLL mask is 0xFF and the LED register and `led_out` are 0x0F.
- R2: The words at offsets 0x000 and 0x004 are read/write over all 32 bits and hold their value until written again.
- R3: Offset 0x100 reads {mask[7:0], lock_in[7:0], 15'b0, summary} from bit 31 down to bit 0. A write there updates only the mask, from pwdata[31:24].
- R4: The summary bit (bit 0 of offset 0x100) is 1 exactly when every DLL whose mask bit is 1 has its `lock_in` bit at 1. It follows `lock_in` and the mask with no write needed.
- R5: Offset 0x104 holds an 8-bit LED value that drives `led_out` directly. A 1 in a bit lights that LED, and bits [31:8] read as zero.
- R6: Offset 0x108 returns `sw_in` in bits [7:0] through a two-flop synchroniser. A change applied just before a rising edge is not visible to a read whose access phase follows that single edge, but it is visible after the second edge. Writes there are ignored.
- R7: Offset 0xFF8 reads {BUILD_NUM[7:0], 8'h00, 5'b0, 3'b111, 8'd2}: bits [10:8] flag the switch, LED and DLL registers as present, and bits [7:0] hold the user-word count. Writes there are ignored.
- R8: Offset 0xFFC reads {8'h41, VARIANT[3:0], 4'h0, 12'h305, REVISION[3:0]}. Writes there are ignored.
- R9: Any other address, including any address with paddr[1:0] not zero, reads as zero and ignores writes. `pready` is 1 and `pslverr` is 0 at all times.
- R10: A register changes only on a rising edge with psel, penable and pwrite all high. A setup phase alone (psel high, penable low) writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high |
| pready | output | 1 | Transfer complete, always 1 |
| pslverr | output | 1 | Transfer error, always 0 |
| lock_in | input | 8 | DLL lock inputs, 1 = locked |
| led_out | output | 8 | LED drive, 1 = lit |
| sw_in | input | 8 | User switch inputs, asynchronous |

## Verification
The bench moves the DLL lock inputs without any bus write between reads. This catches a summary bit that was latched at write time instead of computed live, and a summary that ignores the mask or inverts its sense. It reads the switches one edge and then three edges after a change, so a synchroniser with one stage or none would show the new value too early. It writes to the identification words, the switch word, the upper bits of the lock word, misaligned and unmapped offsets, and issues a setup phase with no access phase. A decoder that aliases addresses or writes in the setup phase would then corrupt a register the bench reads back.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;
  localparam int REG_AW = 12;
  localparam int WORD_W = 32;
  localparam int LANE_W = 8;

  localparam logic [REG_AW-1:0] OFS_USER0 = 12'h000;
  localparam logic [REG_AW-1:0] OFS_USER1 = 12'h004;
  localparam logic [REG_AW-1:0] OFS_LOCK  = 12'h100;
  localparam logic [REG_AW-1:0] OFS_LED   = 12'h104;
  localparam logic [REG_AW-1:0] OFS_SW    = 12'h108;
  localparam logic [REG_AW-1:0] OFS_AUXID = 12'hFF8;
  localparam logic [REG_AW-1:0] OFS_SYSID = 12'hFFC;

  localparam logic [7:0]  USER_COUNT = 8'd2;
  localparam logic [2:0]  PRESENT    = 3'b111;
  localparam logic [7:0]  ID_MAKER   = 8'h41;
  localparam logic [11:0] ID_NUMBER  = 12'h305;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_USER0, SEL_USER1, SEL_LOCK,
    SEL_LED, SEL_SW, SEL_AUXID, SEL_SYSID
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [REG_AW-1:0] a);
    case (a)
      OFS_USER0: return SEL_USER0;
      OFS_USER1: return SEL_USER1;
      OFS_LOCK:  return SEL_LOCK;
      OFS_LED:   return SEL_LED;
      OFS_SW:    return SEL_SW;
      OFS_AUXID: return SEL_AUXID;
      OFS_SYSID: return SEL_SYSID;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_sync2.sv
`timescale 1ns/1ps
module sysctl_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [1:0]   age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
      age    <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
      if (age != 2'd2) age <= age + 2'd1;
    end
  end

  // R6: output equals the input from two edges earlier once both stages are filled
  p_two_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/sysctl_lock_eval.sv
`timescale 1ns/1ps
module sysctl_lock_eval #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lock_in,
  input  logic [N-1:0] mask,
  output logic         all_locked
);
  logic [N-1:0] lane_ok;

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign lane_ok[i] = lock_in[i] | ~mask[i];
  end

  assign all_locked = &lane_ok;

  p_full_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (&lock_in) |-> all_locked);
  p_no_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> all_locked);
  p_enabled_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mask & ~lock_in)) |-> !all_locked);
endmodule

// File: rtl/sysctl_apb_regs.sv
`timescale 1ns/1ps
module sysctl_apb_regs
  import sysctl_pkg::*;
#(
  parameter logic [31:0] USER0_RST = 32'hC0DE_0000,
  parameter logic [31:0] USER1_RST = 32'h0000_C0DE,
  parameter logic [7:0]  BUILD_NUM = 8'h01,
  parameter logic [3:0]  VARIANT   = 4'h0,
  parameter logic [3:0]  REVISION  = 4'h1
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [REG_AW-1:0] paddr,
  input  logic [WORD_W-1:0] pwdata,
  output logic [WORD_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [LANE_W-1:0] lock_in,
  output logic [LANE_W-1:0] led_out,
  input  logic [LANE_W-1:0] sw_in
);
  localparam logic [WORD_W-1:0] AUXID_WORD =
    {BUILD_NUM, 8'h00, 5'b00000, PRESENT, USER_COUNT};
  localparam logic [WORD_W-1:0] SYSID_WORD =
    {ID_MAKER, VARIANT, 4'h0, ID_NUMBER, REVISION};

  reg_sel_e          sel;
  logic              wr_en;
  logic [WORD_W-1:0] user0_q, user1_q;
  logic [LANE_W-1:0] mask_q, led_q, sw_sync;
  logic              summary;
  logic [WORD_W-1:0] rd_word;

  assign sel     = decode_addr(paddr);
  assign wr_en   = psel & penable & pwrite;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign led_out = led_q;

  sysctl_sync2 #(.W(LANE_W)) u_sw_sync (
    .clk(pclk), .rst_n(presetn), .d(sw_in), .q(sw_sync)
  );

  sysctl_lock_eval #(.N(LANE_W)) u_lock (
    .clk(pclk), .rst_n(presetn), .lock_in(lock_in), .mask(mask_q),
    .all_locked(summary)
  );

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      user0_q <= USER0_RST;
      user1_q <= USER1_RST;
      mask_q  <= '1;
      led_q   <= 8'h0F;
    end else if (wr_en) begin
      case (sel)
        SEL_USER0: user0_q <= pwdata;
        SEL_USER1: user1_q <= pwdata;
        SEL_LOCK:  mask_q  <= pwdata[31:24];
        SEL_LED:   led_q   <= pwdata[LANE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_USER0: rd_word = user0_q;
      SEL_USER1: rd_word = user1_q;
      SEL_LOCK:  rd_word = {mask_q, lock_in, 15'b0, summary};
      SEL_LED:   rd_word = {{(WORD_W-LANE_W){1'b0}}, led_q};
      SEL_SW:    rd_word = {{(WORD_W-LANE_W){1'b0}}, sw_sync};
      SEL_AUXID: rd_word = AUXID_WORD;
      SEL_SYSID: rd_word = SYSID_WORD;
      default:   rd_word = '0;
    endcase
  end

  assign prdata = psel ? rd_word : '0;

  p_led_follow_r5: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_en && sel == SEL_LED) |=> (led_out == $past(pwdata[LANE_W-1:0])));
  p_user_hold_r2: assert property (@(posedge pclk) disable iff (!presetn)
    !(wr_en && sel == SEL_USER0) |=> $stable(user0_q));
  p_setup_nowrite_r10: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !penable) |=> ($stable(led_q) && $stable(mask_q) && $stable(user1_q)));
  p_lock_layout_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && sel == SEL_LOCK) |-> (prdata[15:1] == 15'b0 && prdata[23:16] == lock_in));
  p_undef_zero_r9: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && sel == SEL_NONE) |-> (prdata == '0));
  p_sysid_maker_r8: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && sel == SEL_SYSID) |-> (prdata[31:24] == 8'h41));
endmodule

// File: tb/sim_sysctl_apb_regs.sv
`timescale 1ns/1ps
module sim_sysctl_apb_regs;
  localparam logic [31:0] U0 = 32'hC0DE_0000;
  localparam logic [31:0] U1 = 32'h0000_C0DE;

  logic        clk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  lock_in = '0;
  logic [7:0]  led_out;
  logic [7:0]  sw_in = '0;

  always #2.5 clk = ~clk;

  sysctl_apb_regs u0 (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .lock_in(lock_in),
    .led_out(led_out), .sw_in(sw_in)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  logic [31:0] act_q[$];
  string       tag_q[$];
  event        got;

  function automatic void drain();
    while (act_q.size() > 0) begin
      logic [31:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  endfunction

  task automatic push(input logic [31:0] act, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    act_q.push_back(act);
    tag_q.push_back(tag);
    -> got;
  endtask

  initial forever begin
    @(got);
    drain();
  end

  // Tasks start and end at a falling edge
  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk) penable = 1;
    @(negedge clk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  task automatic apb_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk) penable = 1;
    #1 push(prdata, exp, tag);
    @(negedge clk) begin psel = 0; penable = 0; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) presetn = 1;

    // R1 reset state
    push({24'b0, led_out}, 32'h0000_000F, "R1 led_out reset");
    apb_read(12'h000, U0, "R1 user0 reset");
    apb_read(12'h004, U1, "R1 user1 reset");
    apb_read(12'h104, 32'h0000_000F, "R1 led reg reset");
    apb_read(12'h100, 32'hFF00_0000, "R1 R3 mask reset, unlocked");

    // R2 user words
    apb_write(12'h000, 32'hDEAD_BEEF);
    apb_write(12'h004, 32'h1234_5678);
    apb_read(12'h000, 32'hDEAD_BEEF, "R2 user0");
    apb_read(12'h004, 32'h1234_5678, "R2 user1");

    // R4 live summary, R3 mask-only write
    lock_in = 8'hFF;
    apb_read(12'h100, 32'hFFFF_0001, "R4 all locked");
    lock_in = 8'hF7;
    apb_read(12'h100, 32'hFFF7_0000, "R4 one enabled unlocked");
    apb_write(12'h100, 32'h77FF_FFFF);
    apb_read(12'h100, 32'h77F7_0001, "R3 R4 masked lane ignored");
    lock_in = 8'h88;
    apb_read(12'h100, 32'h7788_0000, "R4 live change");
    apb_write(12'h100, 32'h0000_0000);
    lock_in = 8'h00;
    apb_read(12'h100, 32'h0000_0001, "R4 nothing enabled");

    // R5 LEDs
    apb_write(12'h104, 32'hFFFF_FF3C);
    push({24'b0, led_out}, 32'h0000_003C, "R5 led_out");
    apb_read(12'h104, 32'h0000_003C, "R5 led reg upper zero");

    // R6 switches through two stages
    sw_in = 8'hA5;
    apb_read(12'h108, 32'h0000_0000, "R6 one edge not yet visible");
    apb_read(12'h108, 32'h0000_00A5, "R6 visible later");
    apb_write(12'h108, 32'h0000_0011);
    apb_read(12'h108, 32'h0000_00A5, "R6 write ignored");

    // R7 R8 identification
    apb_read(12'hFF8, 32'h0100_0702, "R7 aux id");
    apb_read(12'hFFC, 32'h4100_3051, "R8 system id");
    apb_write(12'hFF8, 32'hFFFF_FFFF);
    apb_write(12'hFFC, 32'h0000_0000);
    apb_read(12'hFF8, 32'h0100_0702, "R7 aux id write ignored");
    apb_read(12'hFFC, 32'h4100_3051, "R8 system id write ignored");

    // R9 undefined and misaligned
    apb_write(12'h00C, 32'hFFFF_FFFF);
    apb_write(12'h001, 32'h0000_0000);
    apb_write(12'h106, 32'h0000_0000);
    apb_read(12'h00C, 32'h0, "R9 undefined reads zero");
    apb_read(12'h200, 32'h0, "R9 unmapped reads zero");
    apb_read(12'h001, 32'h0, "R9 misaligned reads zero");
    apb_read(12'h000, 32'hDEAD_BEEF, "R9 user0 untouched");
    apb_read(12'h104, 32'h0000_003C, "R9 led untouched");
    push({31'b0, pready}, 32'h1, "R9 pready");
    push({31'b0, pslverr}, 32'h0, "R9 pslverr");

    // R10 setup phase alone does not write
    psel = 1; penable = 0; pwrite = 1; paddr = 12'h104; pwdata = 32'h0000_00FF;
    @(negedge clk) begin psel = 0; pwrite = 0; end
    push({24'b0, led_out}, 32'h0000_003C, "R10 led_out after setup only");
    apb_read(12'h104, 32'h0000_003C, "R10 led reg after setup only");

    #1 drain();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule